// File: doc/BRIEF.md
# Isochronous Transmit SYT Timestamp Generator

This block tracks the presentation phase of an isochronous audio transmit stream. The phase is a signed 64-bit count of 24.576 MHz ticks that never wraps. From it the block derives the 16-bit SYT timestamp that the next data packet carries. The phase is anchored once, on the first peek after the stream is armed. The anchor is the current cycle time plus a presentation delay. Optionally, its sub-cycle part is then overwritten with a fixed device constant, and the result is pushed a whole cycle forward if it is not strictly ahead of the current time.

After anchoring, the packetizer peeks whenever it wants the timestamp and the lead for the next data packet. A peek does not move the phase. The packetizer decides which packets carry data, and each data packet it actually emits is reported with a commit strobe, which advances the phase by one packet step. A signed nudge input lets a discipline loop trim the phase.

Top module: `syt_stamp_gen`

## Requirements
- R1: After hardware reset the generator is unseeded: `seeded_o` is 0, `syt_o` reads 0xFFFF ("no timing information") and `valid_o` is 0.
- R2: A peek on `peek_i` with `now_i` is answered on the next cycle. `valid_o` is high for exactly one cycle, and `seeded_now_o` is high in that same cycle only if this peek performed the anchoring.
- R3: With the graft disabled, the first peek after arming sets the phase to `now_i + cfg_delay_i`, and `lead_o` equals the delay.
- R4: With the graft enabled, the anchor keeps the whole-cycle part of `now_i + cfg_delay_i` and replaces its remainder modulo 3072 with `cfg_graft_i` (assumed below 3072). If the result is not strictly greater than `now_i`, 3072 is added once. The resulting lead is strictly positive.
- R5: A peek on a seeded, unarmed generator changes no state. The SYT is unchanged, and `lead_o` reports the phase minus the `now_i` of that peek.
- R6: Each `commit_i` on a seeded generator advances the phase by 4096 ticks (8 frames of 512 ticks). A commit and a nudge in the same cycle both apply.
- R7: `syt_o` is built from the phase modulo 49152. Bits 15:12 hold the cycle index (0 to 15) and bits 11:0 hold the tick offset within that cycle (0 to 3071).
- R8: `nudge_i` adds the signed `nudge_delta_i` to the phase of a seeded generator.
- R9: `restart_i` clears the phase to zero, clears the seeded flag and re-arms. `arm_i` only re-arms: the generator stays seeded, and the next peek re-anchors the phase.
- R10: A commit or nudge before the generator is seeded has no effect, so the following anchoring peek yields exactly the value of R3 or R4.
- R11: Negative phases and negative `now_i` use floor modulo. The anchor remainder and the SYT domain position are always non-negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart_i | input | 1 | Stream restart: unseed, zero phase, re-arm |
| arm_i | input | 1 | Re-arm the anchor for the next peek |
| peek_i | input | 1 | Request SYT and lead for the next data packet |
| now_i | input | 64 | Current cycle time in ticks, signed, sampled on a peek |
| commit_i | input | 1 | One data packet was emitted |
| nudge_i | input | 1 | Apply `nudge_delta_i` to the phase |
| nudge_delta_i | input | 32 | Signed tick correction |
| cfg_delay_i | input | 16 | Presentation delay in ticks (default use 4096) |
| cfg_graft_i | input | 12 | Sub-cycle graft constant (default use 0x0B0) |
| cfg_graft_en_i | input | 1 | Enable the sub-cycle graft |
| syt_o | output | 16 | SYT timestamp, 0xFFFF while unseeded |
| lead_o | output | 64 | Signed lead: phase minus the last peeked time |
| seeded_o | output | 1 | Phase is anchored |
| seeded_now_o | output | 1 | The peek being answered performed the anchoring |
| valid_o | output | 1 | `syt_o` and `lead_o` answer the previous peek |

## Verification
The anchor is swept over current-time values that step by an odd tick count, so it lands on every region of a cycle, including values just below and above the graft constant. These times cover negative values and a large 40-bit epoch. Each time is run with the graft on and off, with three delays and with three graft constants. The sweep separates the cases where the graft moves the phase back and needs the one-cycle correction from those where it does not. Each anchor is followed by a repeated peek at a later time, which tells a pure peek from one that moves the phase. It is also followed by commits, a negative nudge, a combined commit and nudge, and an arm-then-peek re-anchoring, which shows that re-anchoring replaces accumulated steps rather than adding to them.

// File: rtl/syt_stamp_gen.sv
module syt_stamp_gen #(
  parameter int PHASE_W         = 64,
  parameter int DELAY_W         = 16,
  parameter int GRAFT_W         = 12,
  parameter int NUDGE_W         = 32,
  parameter int FRAMES_PER_PKT  = 8,
  parameter int TICKS_PER_FRAME = 512
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      restart_i,
  input  logic                      arm_i,
  input  logic                      peek_i,
  input  logic signed [63:0]        now_i,
  input  logic                      commit_i,
  input  logic                      nudge_i,
  input  logic signed [NUDGE_W-1:0] nudge_delta_i,
  input  logic [DELAY_W-1:0]        cfg_delay_i,
  input  logic [GRAFT_W-1:0]        cfg_graft_i,
  input  logic                      cfg_graft_en_i,
  output logic [15:0]               syt_o,
  output logic signed [63:0]        lead_o,
  output logic                      seeded_o,
  output logic                      seeded_now_o,
  output logic                      valid_o
);

  localparam int DIGITS = (PHASE_W + 1) / 2;
  localparam int WRAP3  = (PHASE_W % 2 == 0) ? 1 : 2;
  localparam logic signed [PHASE_W-1:0] CYC  = PHASE_W'(3072);
  localparam logic signed [PHASE_W-1:0] STEP = PHASE_W'(FRAMES_PER_PKT * TICKS_PER_FRAME);

  // floor(v) mod 3 of a signed value: base-4 digit sum, corrected for the sign weight
  function automatic logic [1:0] fmod3(input logic signed [PHASE_W-1:0] v);
    logic [2*DIGITS-1:0] u;
    int unsigned s;
    u = '0;
    u[PHASE_W-1:0] = v;
    s = 0;
    for (int i = 0; i < DIGITS; i++) s += 32'(u[2*i +: 2]);
    s = s % 3;
    if (v[PHASE_W-1]) s = (s + 3 - WRAP3) % 3;
    return s[1:0];
  endfunction

  // floor modulo 3072 = (floor(x/1024) mod 3) * 1024 + low ten bits
  function automatic logic [11:0] fmod_cyc(input logic signed [PHASE_W-1:0] x);
    return {fmod3(x >>> 10), x[9:0]};
  endfunction

  logic signed [PHASE_W-1:0] phase_q, now_q;
  logic                      seeded_q, armed_q, valid_q, pulse_q;

  logic signed [PHASE_W-1:0] delay_x, graft_x, nudge_x;
  logic signed [PHASE_W-1:0] seed_base, seed_graft, seed_fix, seed_val, step_sum;
  logic                      seeding;

  assign delay_x = PHASE_W'(cfg_delay_i);
  assign graft_x = PHASE_W'(cfg_graft_i);
  assign nudge_x = {{(PHASE_W-NUDGE_W){nudge_delta_i[NUDGE_W-1]}}, nudge_delta_i};

  assign seed_base  = now_i + delay_x;
  assign seed_graft = seed_base - PHASE_W'(fmod_cyc(seed_base)) + graft_x;
  assign seed_fix   = (seed_graft <= now_i) ? seed_graft + CYC : seed_graft;
  assign seed_val   = cfg_graft_en_i ? seed_fix : seed_base;
  assign seeding    = peek_i && (armed_q || !seeded_q);
  assign step_sum   = (commit_i ? STEP : '0) + (nudge_i ? nudge_x : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= '0;
      now_q    <= '0;
      seeded_q <= 1'b0;
      armed_q  <= 1'b1;
      valid_q  <= 1'b0;
      pulse_q  <= 1'b0;
    end else if (restart_i) begin
      phase_q  <= '0;
      now_q    <= '0;
      seeded_q <= 1'b0;
      armed_q  <= 1'b1;
      valid_q  <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      valid_q <= peek_i;
      pulse_q <= seeding;
      if (peek_i) now_q <= now_i;
      if (seeding) begin
        phase_q  <= seed_val;
        seeded_q <= 1'b1;
        armed_q  <= arm_i;
      end else begin
        if (seeded_q) phase_q <= phase_q + step_sum;
        if (arm_i) armed_q <= 1'b1;
      end
    end
  end

  // SYT: cycle index and offset of the phase inside the 16-cycle domain
  logic [5:0]  dom_hi;
  logic [11:0] off_p;
  logic [5:0]  kq;
  logic [8:0]  k11;

  assign dom_hi = {fmod3(phase_q >>> 14), phase_q[13:10]};
  assign off_p  = fmod_cyc(phase_q);
  assign kq     = dom_hi - {4'd0, off_p[11:10]};
  assign k11    = {3'd0, kq} * 9'd11;

  assign syt_o        = seeded_q ? {k11[8:5], off_p} : 16'hFFFF;
  assign lead_o       = phase_q - now_q;
  assign seeded_o     = seeded_q;
  assign seeded_now_o = pulse_q;
  assign valid_o      = valid_q;

  AST_PULSE_IN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    seeded_now_o |-> (valid_o && seeded_o));                                     // R2

  AST_SEED_AHEAD: assert property (@(posedge clk) disable iff (!rst_n)
    seeded_now_o |-> (lead_o >= 0));                                             // R4

  AST_PEEK_PURE: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_o && peek_i && !seeding && !commit_i && !nudge_i && !restart_i)
      |=> $stable(syt_o));                                                       // R5

  AST_COMMIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (seeded_o && commit_i && !nudge_i && !seeding && !restart_i)
      |=> (phase_q == $past(phase_q) + STEP));                                   // R6

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    seeded_o |-> (syt_o[11:0] < 12'd3072));                                      // R7

  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (!seeded_o && syt_o == 16'hFFFF));                             // R9

  AST_UNSEEDED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !seeded_o |-> (phase_q == '0));                                              // R10

endmodule

// File: tb/syt_stamp_gen_bench.sv
module syt_stamp_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               restart_i = 1'b0, arm_i = 1'b0, peek_i = 1'b0;
  logic signed [63:0] now_i = '0;
  logic               commit_i = 1'b0, nudge_i = 1'b0;
  logic signed [31:0] nudge_delta_i = '0;
  logic [15:0]        cfg_delay_i = 16'd4096;
  logic [11:0]        cfg_graft_i = 12'h0B0;
  logic               cfg_graft_en_i = 1'b1;
  logic [15:0]        syt_o;
  logic signed [63:0] lead_o;
  logic               seeded_o, seeded_now_o, valid_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  syt_stamp_gen u_syt_stamp_gen (
    .clk(clk), .rst_n(rst_n), .restart_i(restart_i), .arm_i(arm_i), .peek_i(peek_i),
    .now_i(now_i), .commit_i(commit_i), .nudge_i(nudge_i), .nudge_delta_i(nudge_delta_i),
    .cfg_delay_i(cfg_delay_i), .cfg_graft_i(cfg_graft_i), .cfg_graft_en_i(cfg_graft_en_i),
    .syt_o(syt_o), .lead_o(lead_o), .seeded_o(seeded_o), .seeded_now_o(seeded_now_o),
    .valid_o(valid_o)
  );

  int     n_tests = 0, n_fail = 0;
  longint exp_phase = 0;
  bit     exp_seeded = 0, exp_armed = 1;

  function automatic longint fmod(longint a, longint m);
    longint r = a % m;
    if (r < 0) r += m;
    return r;
  endfunction

  function automatic logic [15:0] enc(longint p);
    longint d = fmod(p, 49152);
    return {4'(d / 3072), 12'(d % 3072)};
  endfunction

  function automatic longint seed_of(longint now);
    longint b = now + longint'(cfg_delay_i);
    longint g;
    if (!cfg_graft_en_i) return b;
    g = b - fmod(b, 3072) + longint'(cfg_graft_i);
    if (g <= now) g += 3072;
    return g;
  endfunction

  task automatic chk(string tag, string what, longint act, longint expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic do_restart();
    @(negedge clk); restart_i = 1'b1;
    @(negedge clk); restart_i = 1'b0;
    exp_phase = 0; exp_seeded = 0; exp_armed = 1;
    chk("R9", "seeded after restart", longint'(seeded_o), 0);
  endtask

  task automatic do_peek(string tag, longint now);
    bit s;
    @(negedge clk); peek_i = 1'b1; now_i = now;
    @(negedge clk); peek_i = 1'b0;
    s = exp_armed || !exp_seeded;
    if (s) begin exp_phase = seed_of(now); exp_seeded = 1; exp_armed = 0; end
    chk(tag, "valid", longint'(valid_o), 1);
    chk(tag, "seed pulse", longint'(seeded_now_o), longint'(s));
    chk(tag, "syt", longint'(syt_o), longint'(enc(exp_phase)));
    chk(tag, "lead", lead_o, exp_phase - now);
  endtask

  task automatic do_step(bit c, bit n, int d);
    @(negedge clk); commit_i = c; nudge_i = n; nudge_delta_i = d;
    @(negedge clk); commit_i = 1'b0; nudge_i = 1'b0;
    if (exp_seeded) exp_phase += (c ? 4096 : 0) + (n ? longint'(d) : 0);
  endtask

  task automatic do_arm();
    @(negedge clk); arm_i = 1'b1;
    @(negedge clk); arm_i = 1'b0;
    exp_armed = 1;
    chk("R9", "seeded kept after arm", longint'(seeded_o), longint'(exp_seeded));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "seeded", longint'(seeded_o), 0);
    chk("R1", "syt", longint'(syt_o), 16'hFFFF);
    chk("R1", "valid", longint'(valid_o), 0);
    rst_n = 1'b1;
    // R10: commit and nudge before seeding are ignored
    do_step(1, 0, 0);
    do_step(0, 1, 777);
    do_step(1, 1, -300);
    chk("R10", "syt while unseeded", longint'(syt_o), 16'hFFFF);
    do_peek("R10", 5000);
    // R2: valid lasts one cycle only
    @(negedge clk);
    chk("R2", "valid drop", longint'(valid_o), 0);
    chk("R2", "pulse drop", longint'(seeded_now_o), 0);

    for (int ge = 0; ge < 2; ge++) begin
      for (int di = 0; di < 3; di++) begin
        for (int gi = 0; gi < 3; gi++) begin
          cfg_graft_en_i = ge[0];
          cfg_delay_i = (di == 0) ? 16'd0 : (di == 1) ? 16'd4096 : 16'd1000;
          cfg_graft_i = (gi == 0) ? 12'h0B0 : (gi == 1) ? 12'd0 : 12'd3071;
          for (int k = 0; k < 41; k++) begin
            longint t = longint'(k) * 1237 - 20000;
            if (k == 40) t = 64'sh0000_0100_0000_0A55;
            do_restart();
            do_peek(ge ? ((t < 0) ? "R11" : "R4") : "R3", t);
            do_peek("R5", t + 50);
            do_step(1, 0, 0); do_step(1, 0, 0); do_step(1, 0, 0);
            do_peek("R6", t + 200);
            do_step(0, 1, -5000);
            do_peek("R8", t + 300);
            do_step(1, 1, 123);
            do_peek("R6", t + 400);
            do_arm();
            do_peek("R9", t + 9000);
            do_peek("R7", t + 9001);
          end
        end
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule